// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block walks a processor core from normal execution into an interrupt handler, one bus cycle at a time. A separate priority unit requests entry and supplies a 16-bit vector address, for example 0xFFEA for the non-maskable interrupt or 0xFFEE for the maskable one. The sequencer then saves the return context on the stack and loads the new program counter from the vector. It drives a byte-wide memory port that has read and write strobes and a ready input.

The core's register file appears as ports. The program counter, program bank, stack pointer, status byte, emulation-mode flag and halted-in-wait flag are sampled when a request is accepted. The updated values are presented when the sequence completes. The steps are as follows. Two internal cycles come first. Then four stack pushes store, in order, the bank byte, the counter high byte, the counter low byte and the status byte. Last come two vector reads. Every stack and vector access is made in bank zero.

Top module: `irq_entry_seq`

## Requirements
- R1: An accepted request yields exactly eight steps: two cycles with both strobes low, then four writes, then two reads. With ready held high, `busy_o` is high for exactly eight consecutive cycles, and the two strobes are never high together.
- R2: The four writes carry, in order, the program bank byte, PC[15:8], PC[7:0] and the status byte.
- R3: Each write goes to address {8'h00, SP}, where SP is the stack pointer at that moment. The pointer decrements by one after each completed write, and `sp_o` shows the final value at completion.
- R4: When `emu_i` is 1 at acceptance, only SP[7:0] decrements and wraps while SP[15:8] stays fixed (0x0101 gives 0x0101, 0x0100, 0x01FF, 0x01FE, and ends at 0x01FD). When `emu_i` is 0, all 16 bits decrement (0x0101 ends at 0x00FD).
- R5: The first read is at {8'h00, V} and the second at {8'h00, V+1}, where V is the vector and V+1 wraps within 16 bits.
- R6: At completion `pc_o` is {second byte, first byte} and `pbank_o` is 0x00. `status_o` equals the saved status with bit 3 (decimal) cleared and bit 2 (interrupt disable) set, and all other bits unchanged.
- R7: If `halted_i` is 1 at acceptance, the pushed counter is PC+1 modulo 2^16 and `wake_o` pulses together with `done_o`. Otherwise `wake_o` stays low.
- R8: `done_o` is high for exactly one cycle: the cycle after the second read completes. `busy_o` is low in that cycle.
- R9: `start_i` is ignored while `busy_o` is high. No extra bus accesses occur and the captured vector and context are unchanged.
- R10: While a strobe is high and `mem_ready_i` is low, the step, address, write data, strobes and stack pointer all hold. Internal cycles do not wait for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Interrupt entry request |
| vector_i | input | 16 | Vector address of the handler pointer |
| halted_i | input | 1 | Core is halted waiting for an interrupt |
| emu_i | input | 1 | Core is in 8-bit emulation mode |
| pc_i | input | 16 | Current program counter |
| pbank_i | input | 8 | Current program bank |
| sp_i | input | 16 | Current stack pointer |
| status_i | input | 8 | Current status byte |
| mem_addr_o | output | 24 | Bus address |
| mem_wdata_o | output | 8 | Bus write data |
| mem_rdata_i | input | 8 | Bus read data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_ready_i | input | 1 | Access completes this cycle when high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wake_o | output | 1 | Core leaves the wait state (with done) |
| pc_o | output | 16 | New program counter |
| pbank_o | output | 8 | New program bank |
| sp_o | output | 16 | Working and final stack pointer |
| status_o | output | 8 | New status byte |

## Verification
The hardest cases to reach combine several conditions at once. One is a stall in the middle of a stack push while the stack pointer is on a page edge in emulation mode. Another is a second request arriving while the sequence is still running. The bench drives ready from a pseudo-random pattern and starts the pointer at 0x0101, so the low-byte wrap falls between stalled pushes. In one run it pulses `start_i` with a different vector in the middle of the sequence. The scoreboard then confirms that only the original six accesses appear. A halted core with PC 0xFFFF and a vector of 0xFFFF cover both 16-bit wraps.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_IDLE0,
      ST_IDLE1,
      ST_PUSH_BANK,
      ST_PUSH_PCH,
      ST_PUSH_PCL,
      ST_PUSH_STAT,
      ST_VEC_LO,
      ST_VEC_HI,
      ST_DONE
   } step_e;

   function automatic logic step_writes(step_e s);
      return (s == ST_PUSH_BANK) || (s == ST_PUSH_PCH) ||
             (s == ST_PUSH_PCL)  || (s == ST_PUSH_STAT);
   endfunction

   function automatic logic step_reads(step_e s);
      return (s == ST_VEC_LO) || (s == ST_VEC_HI);
   endfunction

   function automatic logic step_on_bus(step_e s);
      return step_writes(s) || step_reads(s);
   endfunction

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
   import irq_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  logic  ready_i,
   output step_e step_o,
   output logic  busy_o,
   output logic  done_o,
   output logic  accept_o,
   output logic  advance_o
);

   step_e cur_q;
   step_e nxt;
   logic  idle_w;

   assign idle_w    = (cur_q == ST_OFF) || (cur_q == ST_DONE);
   assign accept_o  = idle_w && start_i;
   assign advance_o = !idle_w && (!step_on_bus(cur_q) || ready_i);
   assign busy_o    = !idle_w;
   assign done_o    = (cur_q == ST_DONE);
   assign step_o    = cur_q;

   always_comb begin
      nxt = cur_q;
      case (cur_q)
         ST_OFF, ST_DONE: nxt = accept_o ? ST_IDLE0 : ST_OFF;
         ST_IDLE0:        nxt = ST_IDLE1;
         ST_IDLE1:        nxt = ST_PUSH_BANK;
         ST_PUSH_BANK:    if (advance_o) nxt = ST_PUSH_PCH;
         ST_PUSH_PCH:     if (advance_o) nxt = ST_PUSH_PCL;
         ST_PUSH_PCL:     if (advance_o) nxt = ST_PUSH_STAT;
         ST_PUSH_STAT:    if (advance_o) nxt = ST_VEC_LO;
         ST_VEC_LO:       if (advance_o) nxt = ST_VEC_HI;
         ST_VEC_HI:       if (advance_o) nxt = ST_DONE;
         default:         nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= ST_OFF;
      else        cur_q <= nxt;
   end

endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
   parameter int SP_W   = 16,
   parameter int PAGE_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [SP_W-1:0] load_val_i,
   input  logic            emu_i,
   input  logic            dec_i,
   output logic [SP_W-1:0] sp_o
);

   localparam int HI_W = SP_W - PAGE_W;

   if (PAGE_W < 1 || PAGE_W > SP_W) begin : g_bad_page
      $error("irq_seq_sp: PAGE_W must lie in 1..SP_W");
   end

   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_full_dec;
   logic [SP_W-1:0] sp_page_dec;

   assign sp_full_dec = sp_q - 1'b1;

   if (HI_W > 0) begin : g_split
      logic [PAGE_W-1:0] low_dec;
      assign low_dec     = sp_q[PAGE_W-1:0] - 1'b1;
      assign sp_page_dec = {sp_q[SP_W-1:PAGE_W], low_dec};
   end else begin : g_whole
      assign sp_page_dec = sp_full_dec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      sp_q <= '0;
      else if (load_i) sp_q <= load_val_i;
      else if (dec_i)  sp_q <= emu_i ? sp_page_dec : sp_full_dec;
   end

   assign sp_o = sp_q;

endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
   import irq_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 24
) (
   input  step_e                 step_i,
   input  logic [2*DATA_W-1:0]   sp_i,
   input  logic [2*DATA_W-1:0]   pc_i,
   input  logic [DATA_W-1:0]     bank_i,
   input  logic [DATA_W-1:0]     status_i,
   input  logic [2*DATA_W-1:0]   vector_i,
   output logic [ADDR_W-1:0]     addr_o,
   output logic [DATA_W-1:0]     wdata_o,
   output logic                  rd_o,
   output logic                  wr_o
);

   localparam int PTR_W  = 2 * DATA_W;
   localparam int BANK_W = ADDR_W - PTR_W;

   logic [PTR_W-1:0] offset;
   logic [PTR_W-1:0] vec_next;

   assign vec_next = vector_i + 1'b1;

   always_comb begin
      offset  = '0;
      wdata_o = '0;
      case (step_i)
         ST_PUSH_BANK: begin offset = sp_i; wdata_o = bank_i; end
         ST_PUSH_PCH:  begin offset = sp_i; wdata_o = pc_i[PTR_W-1:DATA_W]; end
         ST_PUSH_PCL:  begin offset = sp_i; wdata_o = pc_i[DATA_W-1:0]; end
         ST_PUSH_STAT: begin offset = sp_i; wdata_o = status_i; end
         ST_VEC_LO:    offset = vector_i;
         ST_VEC_HI:    offset = vec_next;
         default:      offset = '0;
      endcase
   end

   assign addr_o = {{BANK_W{1'b0}}, offset};
   assign wr_o   = step_writes(step_i);
   assign rd_o   = step_reads(step_i);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 24,
   parameter int PAGE_W      = 8,
   parameter int DEC_BIT     = 3,
   parameter int IRQ_OFF_BIT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [2*DATA_W-1:0] vector_i,
   input  logic                halted_i,
   input  logic                emu_i,
   input  logic [2*DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0]   pbank_i,
   input  logic [2*DATA_W-1:0] sp_i,
   input  logic [DATA_W-1:0]   status_i,
   output logic [ADDR_W-1:0]   mem_addr_o,
   output logic [DATA_W-1:0]   mem_wdata_o,
   input  logic [DATA_W-1:0]   mem_rdata_i,
   output logic                mem_rd_o,
   output logic                mem_wr_o,
   input  logic                mem_ready_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                wake_o,
   output logic [2*DATA_W-1:0] pc_o,
   output logic [DATA_W-1:0]   pbank_o,
   output logic [2*DATA_W-1:0] sp_o,
   output logic [DATA_W-1:0]   status_o
);

   localparam int PTR_W = 2 * DATA_W;

   if (ADDR_W <= PTR_W) begin : g_bad_addr
      $error("irq_entry_seq: ADDR_W must exceed the 16-bit pointer width");
   end
   if (DEC_BIT >= DATA_W || IRQ_OFF_BIT >= DATA_W || DEC_BIT == IRQ_OFF_BIT) begin : g_bad_flags
      $error("irq_entry_seq: flag positions must be distinct and inside the status byte");
   end

   step_e step;
   logic  accept;
   logic  advance;

   logic [PTR_W-1:0]  ctx_pc_q;
   logic [DATA_W-1:0] ctx_bank_q;
   logic [DATA_W-1:0] ctx_stat_q;
   logic [PTR_W-1:0]  ctx_vec_q;
   logic              ctx_halt_q;
   logic              ctx_emu_q;
   logic [DATA_W-1:0] vec_lo_q;
   logic              wake_q;
   logic [DATA_W-1:0] stat_entry;

   irq_seq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .ready_i   (mem_ready_i),
      .step_o    (step),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .accept_o  (accept),
      .advance_o (advance)
   );

   irq_seq_sp #(
      .SP_W   (PTR_W),
      .PAGE_W (PAGE_W)
   ) u_sp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (sp_i),
      .emu_i      (ctx_emu_q),
      .dec_i      (advance && step_writes(step)),
      .sp_o       (sp_o)
   );

   irq_seq_bus #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_bus (
      .step_i   (step),
      .sp_i     (sp_o),
      .pc_i     (ctx_pc_q),
      .bank_i   (ctx_bank_q),
      .status_i (ctx_stat_q),
      .vector_i (ctx_vec_q),
      .addr_o   (mem_addr_o),
      .wdata_o  (mem_wdata_o),
      .rd_o     (mem_rd_o),
      .wr_o     (mem_wr_o)
   );

   always_comb begin
      stat_entry              = ctx_stat_q;
      stat_entry[DEC_BIT]     = 1'b0;
      stat_entry[IRQ_OFF_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_pc_q   <= '0;
         ctx_bank_q <= '0;
         ctx_stat_q <= '0;
         ctx_vec_q  <= '0;
         ctx_halt_q <= 1'b0;
         ctx_emu_q  <= 1'b0;
      end else if (accept) begin
         ctx_pc_q   <= halted_i ? pc_i + 1'b1 : pc_i;
         ctx_bank_q <= pbank_i;
         ctx_stat_q <= status_i;
         ctx_vec_q  <= vector_i;
         ctx_halt_q <= halted_i;
         ctx_emu_q  <= emu_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_lo_q <= '0;
         pc_o     <= '0;
         pbank_o  <= '0;
         status_o <= '0;
         wake_q   <= 1'b0;
      end else if (advance) begin
         if (step == ST_VEC_LO) vec_lo_q <= mem_rdata_i;
         if (step == ST_VEC_HI) begin
            pc_o     <= {mem_rdata_i, vec_lo_q};
            pbank_o  <= '0;
            status_o <= stat_entry;
            wake_q   <= ctx_halt_q;
         end
      end
   end

   assign wake_o = done_o && wake_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 24,
   parameter int DEC_BIT     = 3,
   parameter int IRQ_OFF_BIT = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic [ADDR_W-1:0]   mem_addr_o,
   input logic [DATA_W-1:0]   mem_wdata_o,
   input logic                mem_rd_o,
   input logic                mem_wr_o,
   input logic                mem_ready_i,
   input logic                busy_o,
   input logic                done_o,
   input logic                wake_o,
   input logic [DATA_W-1:0]   pbank_o,
   input logic [2*DATA_W-1:0] sp_o,
   input logic [DATA_W-1:0]   status_o
);

   localparam int PTR_W = 2 * DATA_W;

   // R1
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));

   // R1
   strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || mem_wr_o) |-> busy_o);

   // R3
   bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || mem_wr_o) |-> (mem_addr_o[ADDR_W-1:PTR_W] == '0));

   // R6
   entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!status_o[DEC_BIT] && status_o[IRQ_OFF_BIT] && pbank_o == '0));

   // R7
   wake_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> done_o);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd_o || mem_wr_o) && !mem_ready_i) |=>
         ($stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_rd_o) &&
          $stable(mem_wr_o) && $stable(sp_o)));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .DEC_BIT     (DEC_BIT),
   .IRQ_OFF_BIT (IRQ_OFF_BIT)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_rd_o    (mem_rd_o),
   .mem_wr_o    (mem_wr_o),
   .mem_ready_i (mem_ready_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .wake_o      (wake_o),
   .pbank_o     (pbank_o),
   .sp_o        (sp_o),
   .status_o    (status_o)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

   typedef struct {
      logic        wr;
      logic [23:0] addr;
      logic [7:0]  data;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] vector_i = '0;
   logic        halted_i = 1'b0;
   logic        emu_i = 1'b0;
   logic [15:0] pc_i = '0;
   logic [7:0]  pbank_i = '0;
   logic [15:0] sp_i = '0;
   logic [7:0]  status_i = '0;
   logic [23:0] mem_addr_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  mem_rdata_i;
   logic        mem_rd_o, mem_wr_o;
   logic        mem_ready_i = 1'b1;
   logic        busy_o, done_o, wake_o;
   logic [15:0] pc_o;
   logic [7:0]  pbank_o;
   logic [15:0] sp_o;
   logic [7:0]  status_o;

   int   n_checks = 0;
   int   n_fail = 0;
   exp_t exp_q[$];
   logic        stall_en = 1'b0;
   logic [7:0]  lfsr = 8'hA7;
   logic [15:0] cur_vec = '0;
   logic [7:0]  vec_lo = '0, vec_hi = '0;

   always #10 clk = ~clk;

   irq_entry_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vector_i(vector_i),
      .halted_i(halted_i), .emu_i(emu_i), .pc_i(pc_i), .pbank_i(pbank_i),
      .sp_i(sp_i), .status_i(status_i), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_ready_i(mem_ready_i),
      .busy_o(busy_o), .done_o(done_o), .wake_o(wake_o), .pc_o(pc_o),
      .pbank_o(pbank_o), .sp_o(sp_o), .status_o(status_o)
   );

   assign mem_rdata_i = (mem_addr_o[15:0] == cur_vec) ? vec_lo : vec_hi;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [23:0] act, input logic [23:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ready pattern, driven on the falling edge
   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready_i <= stall_en ? lfsr[0] : 1'b1;
   end

   // monitor: compare completed bus accesses with the scoreboard
   logic        held_prev = 1'b0;
   logic [23:0] held_addr = '0;
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         if (held_prev) begin
            // R10: stalled access holds its address and strobe
            check(mem_addr_o == held_addr && (mem_rd_o || mem_wr_o),
                  "R10", "stalled address", mem_addr_o, held_addr);
         end
         held_prev = (mem_rd_o || mem_wr_o) && !mem_ready_i;
         held_addr = mem_addr_o;
         if ((mem_rd_o || mem_wr_o) && mem_ready_i) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected access", mem_addr_o, 24'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(mem_wr_o == e.wr, e.req, "access kind", {23'h0, mem_wr_o}, {23'h0, e.wr});
               check(mem_addr_o == e.addr, e.req, "address", mem_addr_o, e.addr);
               if (e.wr)
                  check(mem_wdata_o == e.data, e.req, "write data", {16'h0, mem_wdata_o}, {16'h0, e.data});
            end
         end
      end
   end

   function automatic logic [15:0] sp_dec(input logic [15:0] s, input logic emu);
      return emu ? {s[15:8], s[7:0] - 8'h01} : s - 16'h0001;
   endfunction

   task automatic run_entry(input logic [15:0] vec, input logic [15:0] pc,
                            input logic [7:0] bank, input logic [15:0] sp,
                            input logic [7:0] stat, input logic emu,
                            input logic halted, input logic [7:0] lo,
                            input logic [7:0] hi, input logic stall,
                            input logic inject);
      logic [15:0] s;
      logic [15:0] pushed_pc;
      exp_t e;
      int   busy_cnt;
      int   cyc;
      s = sp;
      pushed_pc = halted ? pc + 16'h0001 : pc;
      e.wr = 1'b1; e.req = "R2";
      e.addr = {8'h00, s}; e.data = bank;            exp_q.push_back(e); s = sp_dec(s, emu);
      e.addr = {8'h00, s}; e.data = pushed_pc[15:8]; e.req = halted ? "R7" : "R2"; exp_q.push_back(e); s = sp_dec(s, emu);
      e.addr = {8'h00, s}; e.data = pushed_pc[7:0];  exp_q.push_back(e); s = sp_dec(s, emu);
      e.addr = {8'h00, s}; e.data = stat; e.req = "R3"; exp_q.push_back(e); s = sp_dec(s, emu);
      e.wr = 1'b0; e.data = 8'h00; e.req = "R5";
      e.addr = {8'h00, vec};          exp_q.push_back(e);
      e.addr = {8'h00, vec + 16'h1};  exp_q.push_back(e);

      @(negedge clk);
      stall_en = stall;
      cur_vec = vec; vec_lo = lo; vec_hi = hi;
      vector_i = vec; pc_i = pc; pbank_i = bank; sp_i = sp;
      status_i = stat; emu_i = emu; halted_i = halted;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      busy_cnt = 0;
      for (cyc = 0; cyc < 400; cyc++) begin
         #2;
         if (done_o) break;
         if (busy_o) busy_cnt++;
         if (cyc < 2)
            // R1: two internal cycles without strobes
            check(busy_o && !mem_rd_o && !mem_wr_o, "R1", "idle step",
                  {21'h0, busy_o, mem_rd_o, mem_wr_o}, 24'h4);
         if (inject && cyc == 3) begin
            vector_i = 16'h1234; sp_i = 16'h0042; start_i = 1'b1;
         end
         @(negedge clk);
         start_i = 1'b0;
      end
      stall_en = 1'b0;
      check(done_o, "R8", "done seen", {23'h0, done_o}, 24'h1);
      check(!busy_o, "R8", "busy low at done", {23'h0, busy_o}, 24'h0);
      if (!stall)
         check(busy_cnt == 8, "R1", "busy cycles", busy_cnt[23:0], 24'd8);
      check(pc_o == {hi, lo}, "R6", "new pc", {8'h0, pc_o}, {8'h0, hi, lo});
      check(pbank_o == 8'h00, "R6", "new bank", {16'h0, pbank_o}, 24'h0);
      check(status_o == ((stat & 8'hF7) | 8'h04), "R6", "new status",
            {16'h0, status_o}, {16'h0, (stat & 8'hF7) | 8'h04});
      check(sp_o == s, emu ? "R4" : "R3", "final sp", {8'h0, sp_o}, {8'h0, s});
      check(wake_o == halted, "R7", "wake", {23'h0, wake_o}, {23'h0, halted});
      check(exp_q.size() == 0, "R9", "pending accesses", exp_q.size(), 24'h0);
      @(negedge clk);
      #2;
      check(!done_o && !busy_o, "R8", "single done pulse",
            {22'h0, done_o, busy_o}, 24'h0);
      exp_q.delete();
   endtask

   initial begin : watchdog
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      check(!busy_o && !done_o && !mem_rd_o && !mem_wr_o, "R8", "reset state",
            {20'h0, busy_o, done_o, mem_rd_o, mem_wr_o}, 24'h0);
      // NMI entry, native mode, decimal flag set on entry
      run_entry(16'hFFEA, 16'h8123, 8'h7E, 16'h1FF0, 8'h3B, 1'b0, 1'b0, 8'h34, 8'h92, 1'b0, 1'b0);
      // IRQ entry, emulation mode, low byte wraps inside the page (R4)
      run_entry(16'hFFEE, 16'h4000, 8'h00, 16'h0101, 8'h08, 1'b1, 1'b0, 8'h00, 8'hC0, 1'b0, 1'b0);
      // native mode crosses the page (R4)
      run_entry(16'hFFEE, 16'h4000, 8'h12, 16'h0101, 8'hFF, 1'b0, 1'b0, 8'h55, 8'hAA, 1'b0, 1'b0);
      // halted core, pc wraps, random stalls (R7, R10)
      run_entry(16'hFFEA, 16'hFFFF, 8'h01, 16'h01FF, 8'h00, 1'b1, 1'b1, 8'h10, 8'h20, 1'b1, 1'b0);
      // stalled emulation entry with a request during the sequence (R9, R10)
      run_entry(16'hFFEE, 16'h2345, 8'h80, 16'h0101, 8'h0C, 1'b1, 1'b0, 8'h78, 8'h56, 1'b1, 1'b1);
      // unstalled request during the sequence (R9)
      run_entry(16'hFFEA, 16'h0BAD, 8'h33, 16'h3000, 8'h80, 1'b0, 1'b0, 8'h01, 8'h02, 1'b0, 1'b1);
      // vector at 0xFFFF: high byte read wraps to 0x0000 (R5)
      run_entry(16'hFFFF, 16'h1000, 8'h05, 16'h0200, 8'h04, 1'b0, 1'b0, 8'hEF, 8'hBE, 1'b0, 1'b0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule